// File: doc/BRIEF.md
# Maskable Interrupt Status Controller

This block gathers event pulses from a periodic monitoring sequencer and turns them into two banks of 8-bit interrupt status. Events seen during one monitoring pass are staged internally. When the sequencer signals that the pass is done, they are merged into the status banks. Two hardware interrupt lines are derived from the status: a primary line (NMI/IRQ) and a system-management line (SMI). Each line has its own per-bit mask registers and its own enable.

Software reaches the block through a simple register bus. Reading a status bank returns its contents and clears it in the same access. The bank then stays clear until the next completed pass. A configuration register holds both line enables, the signalling mode of the primary line (level or single-cycle pulse), and a clear control. While the clear control is set, both lines are held inactive and the monitoring loop is told to stop.

Top module: `irq_status_ctrl`

## Requirements
- R1: After synchronous reset, the block starts in this state:
  - both status banks read 0x00;
  - all four mask registers read 0xFF;
  - the configuration register reads 0x00;
  - both lines are low;
  - bus_rdata is 0x00.
- R2: Events on mon_evt are collected during a pass and reach the status banks only on a cycle with mon_done high. An event in that same cycle is included. Status bit i (0..7) is bit i of bank 0 at address 0. Status bit i (8..15) is bit i-8 of bank 1 at address 1. Before mon_done, a read of a bank returns 0x00.
- R3: A read of a status bank puts its contents on bus_rdata one clock later and clears the bank in the same clock. A second read before the next pass returns 0x00, and the line driven by that bank drops one clock after the clearing read.
- R4: When mon_done coincides with a clearing read of a bank, the read returns the old contents and the newly merged bits stay set. The next read returns them.
- R5: A status bit contributes to a line only while that line's mask bit is 0. Primary-line masks are at addresses 2 (bits 7..0) and 3 (bits 15..8). SMI masks are at addresses 4 (bits 7..0) and 5 (bits 15..8).
- R6: Configuration register (address 6) bit 0 enables the SMI line and bit 1 enables the primary line. A disabled line stays low.
- R7: In level mode (configuration bit 2 = 0), an enabled line is high whenever any unmasked status bit is set. The line is registered: it follows the status or mask state of the previous clock.
- R8: With configuration bit 2 = 1, the primary line emits a one-clock pulse when a new unmasked status bit appears. An already-present bit that is set again produces no pulse. The SMI line always uses level mode.
- R9: While configuration bit 3 is 1:
  - both lines are low from the next clock on;
  - mon_halt is high;
  - mon_evt and mon_done are ignored.
  Clearing the bit resumes collection, and status left unread drives the lines again.
- R10: Mask and configuration registers read back the last written byte. Addresses 7 to 15 read 0x00 and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 4 | Register address |
| bus_wr | input | 1 | Write strobe, one clock per write |
| bus_rd | input | 1 | Read strobe, one clock per read |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid the clock after bus_rd, held until the next read |
| mon_evt | input | 16 | Event pulses from the monitoring sequencer, one bit per source |
| mon_done | input | 1 | End-of-pass strobe from the monitoring sequencer |
| mon_halt | output | 1 | Stop request to the monitoring sequencer (clear control active) |
| nmi_irq_o | output | 1 | Primary interrupt line, active high |
| smi_o | output | 1 | System-management interrupt line, active high |

## Verification
Inputs are driven at falling edges, so each result has a fixed due time.
- A write, read or end-of-pass strobe takes effect on the next rising edge. Register and status values are observed at the falling edge right after that edge.
- The lines are one register further on. The bench waits one more falling edge before sampling them.
- A primary-line pulse must be high at exactly that sample and low at the one after it.
- Each source bit is swept under masked and unmasked settings. The expected line level and bank contents are computed from the bit index.

// File: rtl/irq_status_pkg.sv
package irq_status_pkg;

    localparam int REG_BYTES = 8;

    // configuration byte, bit positions fixed by the register map
    typedef struct packed {
        logic [3:0] spare;
        logic       halt_clr;    // bit 3
        logic       pri_pulse;   // bit 2
        logic       pri_en;      // bit 1
        logic       sys_en;      // bit 0
    } cfg_t;

    typedef enum logic [1:0] {
        LINE_LEVEL = 2'd0,
        LINE_PULSE = 2'd1
    } line_mode_e;

    function automatic line_mode_e mode_of(input cfg_t c);
        return c.pri_pulse ? LINE_PULSE : LINE_LEVEL;
    endfunction

    // bits that are set and not blocked by a mask
    function automatic logic any_unmasked(input logic [63:0] st, input logic [63:0] mk);
        return |(st & ~mk);
    endfunction

endpackage

// File: rtl/irq_regfile.sv
module irq_regfile
    import irq_status_pkg::*;
#(
    parameter int N_BANK = 2,
    parameter int REG_W  = 8,
    parameter int ADDR_W = 4,
    localparam int N_SRC = N_BANK * REG_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [REG_W-1:0]  bus_wdata,
    output logic [REG_W-1:0]  bus_rdata,
    input  logic [N_SRC-1:0]  stat_q,
    output cfg_t              cfg_q,
    output logic [N_SRC-1:0]  pmask_q,
    output logic [N_SRC-1:0]  smask_q,
    output logic [N_BANK-1:0] rd_clr
);
    localparam int PMSK_BASE = N_BANK;
    localparam int SMSK_BASE = 2 * N_BANK;
    localparam int CFG_ADDR  = 3 * N_BANK;

    logic [REG_W-1:0] rd_mux;

    // per-bank clear strobe for the status banks
    always_comb begin
        for (int b = 0; b < N_BANK; b++) begin
            rd_clr[b] = bus_rd && (bus_addr == ADDR_W'(b));
        end
    end

    always_comb begin
        rd_mux = '0;
        for (int b = 0; b < N_BANK; b++) begin
            if (bus_addr == ADDR_W'(b))
                rd_mux = stat_q[b*REG_W +: REG_W];
            if (bus_addr == ADDR_W'(PMSK_BASE + b))
                rd_mux = pmask_q[b*REG_W +: REG_W];
            if (bus_addr == ADDR_W'(SMSK_BASE + b))
                rd_mux = smask_q[b*REG_W +: REG_W];
        end
        if (bus_addr == ADDR_W'(CFG_ADDR))
            rd_mux = REG_W'(cfg_q);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q     <= '0;
            pmask_q   <= '1;
            smask_q   <= '1;
            bus_rdata <= '0;
        end else begin
            if (bus_wr) begin
                for (int b = 0; b < N_BANK; b++) begin
                    if (bus_addr == ADDR_W'(PMSK_BASE + b))
                        pmask_q[b*REG_W +: REG_W] <= bus_wdata;
                    if (bus_addr == ADDR_W'(SMSK_BASE + b))
                        smask_q[b*REG_W +: REG_W] <= bus_wdata;
                end
                if (bus_addr == ADDR_W'(CFG_ADDR))
                    cfg_q <= cfg_t'(bus_wdata);
            end
            if (bus_rd)
                bus_rdata <= rd_mux;
        end
    end

endmodule

// File: rtl/irq_status_bank.sv
module irq_status_bank #(
    parameter int REG_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [REG_W-1:0] evt,
    input  logic             pass_done,
    input  logic             halt,
    input  logic             rd_clr,
    output logic [REG_W-1:0] stat_q
);
    logic [REG_W-1:0] pend_q;
    logic [REG_W-1:0] kept;

    // a clearing read drops the old contents, never the newly merged ones
    assign kept = rd_clr ? '0 : stat_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            stat_q <= '0;
            pend_q <= '0;
        end else if (halt) begin
            stat_q <= kept;
        end else if (pass_done) begin
            stat_q <= kept | pend_q | evt;
            pend_q <= '0;
        end else begin
            stat_q <= kept;
            pend_q <= pend_q | evt;
        end
    end

endmodule

// File: rtl/irq_line_drv.sv
module irq_line_drv
    import irq_status_pkg::*;
#(
    parameter int N_SRC = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [N_SRC-1:0] stat,
    input  logic [N_SRC-1:0] mask,
    input  logic             en,
    input  logic             clr,
    input  line_mode_e       mode,
    output logic             line
);
    logic [N_SRC-1:0] unm;
    logic [N_SRC-1:0] prev_unm_q;
    logic             fresh;
    logic             level;
    logic             line_d;

    assign unm   = stat & ~mask;
    assign level = any_unmasked(64'(stat), 64'(mask));
    assign fresh = |(unm & ~prev_unm_q);

    always_comb begin
        unique case (mode)
            LINE_PULSE: line_d = fresh;
            default:    line_d = level;
        endcase
        line_d = line_d && en && !clr;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_unm_q <= '0;
            line       <= 1'b0;
        end else begin
            prev_unm_q <= unm;
            line       <= line_d;
        end
    end

endmodule

// File: rtl/irq_status_ctrl.sv
module irq_status_ctrl
    import irq_status_pkg::*;
#(
    parameter int N_BANK = 2,
    parameter int REG_W  = REG_BYTES,
    parameter int ADDR_W = 4,
    localparam int N_SRC = N_BANK * REG_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [REG_W-1:0]  bus_wdata,
    output logic [REG_W-1:0]  bus_rdata,
    input  logic [N_SRC-1:0]  mon_evt,
    input  logic              mon_done,
    output logic              mon_halt,
    output logic              nmi_irq_o,
    output logic              smi_o
);
    cfg_t              cfg_q;
    logic [N_SRC-1:0]  stat_q;
    logic [N_SRC-1:0]  pmask_q;
    logic [N_SRC-1:0]  smask_q;
    logic [N_BANK-1:0] rd_clr;

    assign mon_halt = cfg_q.halt_clr;

    irq_regfile #(
        .N_BANK (N_BANK),
        .REG_W  (REG_W),
        .ADDR_W (ADDR_W)
    ) regs_i (
        .clk       (clk),
        .rst       (rst),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .stat_q    (stat_q),
        .cfg_q     (cfg_q),
        .pmask_q   (pmask_q),
        .smask_q   (smask_q),
        .rd_clr    (rd_clr)
    );

    for (genvar b = 0; b < N_BANK; b++) begin : g_bank
        irq_status_bank #(.REG_W(REG_W)) bank_i (
            .clk       (clk),
            .rst       (rst),
            .evt       (mon_evt[b*REG_W +: REG_W]),
            .pass_done (mon_done),
            .halt      (cfg_q.halt_clr),
            .rd_clr    (rd_clr[b]),
            .stat_q    (stat_q[b*REG_W +: REG_W])
        );
    end

    irq_line_drv #(.N_SRC(N_SRC)) pri_line_i (
        .clk  (clk),
        .rst  (rst),
        .stat (stat_q),
        .mask (pmask_q),
        .en   (cfg_q.pri_en),
        .clr  (cfg_q.halt_clr),
        .mode (mode_of(cfg_q)),
        .line (nmi_irq_o)
    );

    irq_line_drv #(.N_SRC(N_SRC)) sys_line_i (
        .clk  (clk),
        .rst  (rst),
        .stat (stat_q),
        .mask (smask_q),
        .en   (cfg_q.sys_en),
        .clr  (cfg_q.halt_clr),
        .mode (LINE_LEVEL),
        .line (smi_o)
    );

endmodule

// File: rtl/irq_status_chk.sv
module irq_status_chk #(
    parameter int N_SRC = 16,
    parameter int REG_W = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             bus_rd,
    input logic [3:0]       bus_addr,
    input logic             mon_done,
    input logic             nmi_irq_o,
    input logic             smi_o,
    input logic [7:0]       cfg_bits,
    input logic [N_SRC-1:0] stat_q,
    input logic [N_SRC-1:0] smask_q
);
    // R2: a status bit may only rise after an end-of-pass strobe outside halt
    a_r2_rise_on_pass: assert property (@(posedge clk) disable iff (rst)
        ((stat_q & ~$past(stat_q)) != '0) |-> $past(mon_done && !cfg_bits[3]));

    // R3: a clearing read of bank 0 without a coincident pass leaves it empty
    a_r3_read_clears: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && bus_addr == 4'd0 && !mon_done) |=> (stat_q[REG_W-1:0] == '0));

    // R5: the SMI line only rises for an unmasked status bit
    a_r5_smi_cause: assert property (@(posedge clk) disable iff (rst)
        smi_o |-> $past((stat_q & ~smask_q) != '0));

    // R6: a disabled SMI line stays low
    a_r6_smi_disabled: assert property (@(posedge clk) disable iff (rst)
        !cfg_bits[0] |=> !smi_o);

    // R9: clear control holds both lines low
    a_r9_lines_low: assert property (@(posedge clk) disable iff (rst)
        cfg_bits[3] |=> (!smi_o && !nmi_irq_o));

    // R9: no status bit rises while halted
    a_r9_frozen: assert property (@(posedge clk) disable iff (rst)
        cfg_bits[3] |=> ((stat_q & ~$past(stat_q)) == '0));

endmodule

bind irq_status_ctrl irq_status_chk #(.N_SRC(N_SRC), .REG_W(REG_W)) chk_i (
    .clk       (clk),
    .rst       (rst),
    .bus_rd    (bus_rd),
    .bus_addr  (bus_addr),
    .mon_done  (mon_done),
    .nmi_irq_o (nmi_irq_o),
    .smi_o     (smi_o),
    .cfg_bits  (8'(cfg_q)),
    .stat_q    (stat_q),
    .smask_q   (smask_q)
);

// File: tb/irq_status_ctrl_tb_top.sv
module irq_status_ctrl_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic [15:0] mon_evt = '0;
    logic        mon_done = 1'b0;
    logic        mon_halt;
    logic        nmi_irq_o;
    logic        smi_o;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;
    logic [7:0] rv;

    always #5 clk = ~clk;

    irq_status_ctrl dut_i (
        .clk       (clk),
        .rst       (rst),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .mon_evt   (mon_evt),
        .mon_done  (mon_done),
        .mon_halt  (mon_halt),
        .nmi_irq_o (nmi_irq_o),
        .smi_o     (smi_o)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [7:0] d);
        bus_addr = a; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    task automatic pass(input logic [15:0] e);
        mon_evt = e; mon_done = 1'b1;
        @(negedge clk);
        mon_evt = '0; mon_done = 1'b0;
    endtask

    task automatic evt_only(input logic [15:0] e);
        mon_evt = e;
        @(negedge clk);
        mon_evt = '0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=%h expected=%h", 16'd0, 16'd1);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        step();

        // R1 reset state
        chk("R1 nmi", 16'(nmi_irq_o), 16'd0);
        chk("R1 smi", 16'(smi_o), 16'd0);
        chk("R1 rdata", 16'(bus_rdata), 16'd0);
        rd(4'd6, rv); chk("R1 cfg", 16'(rv), 16'h00);
        for (int a = 2; a < 6; a++) begin
            rd(4'(a), rv); chk("R1 mask", 16'(rv), 16'hFF);
        end
        rd(4'd0, rv); chk("R1 stat0", 16'(rv), 16'h00);
        rd(4'd1, rv); chk("R1 stat1", 16'(rv), 16'h00);

        // R5 R7 R3 sweep: every source, SMI masked or unmasked, primary masked
        wr(4'd6, 8'h03);
        for (int s = 0; s < 16; s++) begin
            for (int m = 0; m < 2; m++) begin
                logic [15:0] bitv;
                logic [15:0] smask;
                bitv  = 16'h1 << s;
                smask = (m == 1) ? 16'hFFFF : ~bitv;
                wr(4'd4, smask[7:0]);
                wr(4'd5, smask[15:8]);
                pass(bitv);
                step();
                chk("R5 R7 smi level", 16'(smi_o), 16'(m == 0));
                chk("R5 nmi masked", 16'(nmi_irq_o), 16'd0);
                rd(4'(s / 8), rv);
                chk("R2 R3 own bank", 16'(rv), 16'(8'h1 << (s % 8)));
                rd(4'(1 - s / 8), rv);
                chk("R2 other bank", 16'(rv), 16'd0);
                chk("R3 line drops", 16'(smi_o), 16'd0);
                rd(4'(s / 8), rv);
                chk("R3 reread zero", 16'(rv), 16'd0);
            end
        end
        wr(4'd4, 8'hFF); wr(4'd5, 8'hFF);

        // R2 accumulation across a pass
        evt_only(16'h0011);
        evt_only(16'h8200);
        rd(4'd0, rv); chk("R2 before pass", 16'(rv), 16'd0);
        pass(16'h0002);
        rd(4'd0, rv); chk("R2 merged bank0", 16'(rv), 16'h13);
        rd(4'd1, rv); chk("R2 merged bank1", 16'(rv), 16'h82);

        // R4 read coinciding with end of pass
        pass(16'h0002);
        evt_only(16'h0004);
        bus_addr = 4'd0; bus_rd = 1'b1; mon_done = 1'b1;
        step();
        bus_rd = 1'b0; mon_done = 1'b0;
        chk("R4 old contents", 16'(bus_rdata), 16'h02);
        rd(4'd0, rv); chk("R4 new bits kept", 16'(rv), 16'h04);

        // R6 enables
        wr(4'd2, 8'h00); wr(4'd4, 8'h00);
        wr(4'd6, 8'h01);
        pass(16'h0008);
        step();
        chk("R6 smi on", 16'(smi_o), 16'd1);
        chk("R6 nmi off", 16'(nmi_irq_o), 16'd0);
        wr(4'd6, 8'h02);
        step();
        chk("R6 smi off", 16'(smi_o), 16'd0);
        chk("R6 nmi on", 16'(nmi_irq_o), 16'd1);
        rd(4'd0, rv);

        // R8 pulse mode on the primary line
        wr(4'd6, 8'h07);
        pass(16'h0001);
        chk("R8 pre", 16'(nmi_irq_o), 16'd0);
        step();
        chk("R8 pulse high", 16'(nmi_irq_o), 16'd1);
        chk("R8 smi level", 16'(smi_o), 16'd1);
        step();
        chk("R8 pulse one clock", 16'(nmi_irq_o), 16'd0);
        chk("R8 smi stays", 16'(smi_o), 16'd1);
        pass(16'h0001);
        step();
        chk("R8 no repeat", 16'(nmi_irq_o), 16'd0);
        pass(16'h0002);
        step();
        chk("R8 new bit pulse", 16'(nmi_irq_o), 16'd1);
        rd(4'd0, rv);

        // R9 clear control
        wr(4'd6, 8'h03);
        pass(16'h0020);
        step();
        chk("R9 line before", 16'(smi_o), 16'd1);
        wr(4'd6, 8'h0B);
        chk("R9 halt out", 16'(mon_halt), 16'd1);
        step();
        chk("R9 smi low", 16'(smi_o), 16'd0);
        chk("R9 nmi low", 16'(nmi_irq_o), 16'd0);
        evt_only(16'h0040);
        pass(16'h0080);
        wr(4'd6, 8'h03);
        chk("R9 halt released", 16'(mon_halt), 16'd0);
        step();
        chk("R9 line resumes", 16'(smi_o), 16'd1);
        rd(4'd0, rv); chk("R9 events ignored", 16'(rv), 16'h20);

        // R10 readback and unmapped addresses
        wr(4'd3, 8'hA5); rd(4'd3, rv); chk("R10 mask rb", 16'(rv), 16'hA5);
        wr(4'd5, 8'h3C); rd(4'd5, rv); chk("R10 smask rb", 16'(rv), 16'h3C);
        wr(4'd6, 8'hF3); rd(4'd6, rv); chk("R10 cfg rb", 16'(rv), 16'hF3);
        for (int a = 7; a < 16; a++) begin
            wr(4'(a), 8'h5A);
            rd(4'(a), rv); chk("R10 unmapped", 16'(rv), 16'h00);
        end
        rd(4'd3, rv); chk("R10 untouched", 16'(rv), 16'hA5);
        rd(4'd6, rv); chk("R10 cfg untouched", 16'(rv), 16'hF3);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule